// File: doc/BRIEF.md
# DDR command decoder with mode registers

This block sits at the command input of a DDR memory device model or controller-facing front end. On every rising clock edge it samples chip select, the three row/column/write strobes, the bank address and the address bus. It turns that sample into a single-cycle, one-hot command strobe. Alongside the strobe it presents the bank and the row or column address that the command carries, and a qualifier bit. For reads and writes the qualifier means auto precharge. For precharge it means all banks.

The same sample also feeds two mode registers. A load-mode command selects the base or the extended register by bank address. The block checks the operand for reserved encodings. A legal operand is applied at the same edge, and the decoded fields are driven out continuously: burst length code, burst type, CAS latency code, a DLL-reset pulse and DLL enable. An illegal operand raises a one-cycle error pulse, and the stored fields stay as they were. Power-down sequencing and the data path are handled elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: With clock enable high and chip select high at an edge, the cycle after shows only the NOP strobe (bit 0 of `cmd_oh_o`), and the mode fields do not change.
- R2: With clock enable high and chip select low, {ras_n,cas_n,we_n} decodes to one strobe bit of `cmd_oh_o`, visible the cycle after the sampling edge. The mapping is 111 NOP bit 0, 011 ACTIVE bit 1, 101 READ bit 2, 100 WRITE bit 3, 110 BURST STOP bit 4, 010 PRECHARGE bit 5, 000 LOAD MODE bit 8. At most one bit is ever set.
- R3: The refresh encoding 001 gives the auto-refresh strobe (bit 6) when clock enable is high and the self-refresh-entry strobe (bit 7) when clock enable is low. With clock enable low, every other input gives no strobe at all.
- R4: `qual_o` equals A10 for READ, WRITE and PRECHARGE and is 0 for every other command.
- R5: ACTIVE reports the bank and the full row address. READ and WRITE report the bank and the column A9:A0, with the upper address bits zero. PRECHARGE with A10 high reports bank 0 whatever BA is, and PRECHARGE with A10 low reports BA. All other commands report bank 0 and address 0.
- R6: LOAD MODE with BA=00 and a legal operand updates the base fields the cycle after. The fields are burst length code A2:A0 (001=2, 010=4, 011=8), burst type A3 (0 sequential, 1 interleaved) and CAS latency code A6:A4 (010=2, 011=3).
- R7: A base write whose A11:A7 is 00010 (only A8 set) is legal, applies its fields and raises `dll_rst_o` for exactly one cycle. Any later command that is not such a write leaves it low.
- R8: A load-mode write is rejected in these cases: BA=10 or 11; a base operand with burst length code outside 001..011; a CAS code outside 010/011; A11:A7 other than 00000 or 00010; an extended operand with any of A11:A1 set. A rejected write raises `mr_err_o` for one cycle and leaves every stored field unchanged.
- R9: LOAD MODE with BA=01 and a legal operand sets `dll_en_o` to the inverse of A0.
- R10: During and after reset the outputs show no strobe, zero bank, zero address, no qualifier and no error. The mode fields read burst code 010, sequential, CAS code 011, DLL enabled and no DLL reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | BA_W | Bank address / mode register select |
| addr_i | input | ADDR_W | Row, column or mode operand |
| cmd_oh_o | output | 9 | One-hot command strobe |
| bank_o | output | BA_W | Bank of the reported command |
| addr_o | output | ADDR_W | Row or column of the reported command |
| qual_o | output | 1 | Auto-precharge / all-banks qualifier |
| bl_o | output | 3 | Burst length code |
| bt_o | output | 1 | Burst type, 1 = interleaved |
| cl_o | output | 3 | CAS latency code |
| dll_rst_o | output | 1 | One-cycle DLL reset pulse |
| dll_en_o | output | 1 | DLL enable |
| mr_err_o | output | 1 | One-cycle reserved-encoding error |

## Verification
The assertions take for granted that every command input carries a defined 0 or 1 at each sampling edge once reset is released, and that reset is held across at least one rising edge before the first command. The properties that look one edge back, on clock enable and chip select, depend on this. The stimulus changes inputs only a short time after each rising edge and never drives unknown values. Every load-mode operand in the sequence is picked so that each rejection case of the mode check, and each legal field value, occurs at least once.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    localparam int CMD_N  = 9;
    localparam int C_NOP  = 0;
    localparam int C_ACT  = 1;
    localparam int C_RD   = 2;
    localparam int C_WR   = 3;
    localparam int C_BST  = 4;
    localparam int C_PRE  = 5;
    localparam int C_AREF = 6;
    localparam int C_SREF = 7;
    localparam int C_LMR  = 8;

    typedef logic [2:0] opc_t;
    localparam opc_t OPC_NOP = 3'b111;
    localparam opc_t OPC_ACT = 3'b011;
    localparam opc_t OPC_RD  = 3'b101;
    localparam opc_t OPC_WR  = 3'b100;
    localparam opc_t OPC_BST = 3'b110;
    localparam opc_t OPC_PRE = 3'b010;
    localparam opc_t OPC_REF = 3'b001;
    localparam opc_t OPC_LMR = 3'b000;

    typedef struct packed {
        logic [2:0] bl;
        logic       bt;
        logic [2:0] cl;
        logic       dll_rst;
        logic       dll_en;
    } mode_t;

    localparam mode_t MODE_RST = '{bl: 3'b010, bt: 1'b0, cl: 3'b011,
                                   dll_rst: 1'b0, dll_en: 1'b1};

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [CMD_N-1:0]  cmd,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] aout,
    output logic              qual
);

    logic [ADDR_W-1:0] col_ext;
    opc_t              opc;

    // Column address widened to the bus width; the parameters pick the variant.
    generate
        if (ADDR_W > COL_W) begin : g_colpad
            assign col_ext = {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end else begin : g_colfull
            assign col_ext = addr;
        end
    endgenerate

    assign opc = {ras_n, cas_n, we_n};

    always_comb begin
        cmd  = '0;
        bank = '0;
        aout = '0;
        qual = 1'b0;
        if (!cke) begin
            // Clock disabled: only self-refresh entry is recognised.
            if (!cs_n && opc == OPC_REF) begin
                cmd[C_SREF] = 1'b1;
            end
        end else if (cs_n) begin
            cmd[C_NOP] = 1'b1;
        end else begin
            case (opc)
                OPC_NOP: cmd[C_NOP] = 1'b1;
                OPC_ACT: begin
                    cmd[C_ACT] = 1'b1;
                    bank       = ba;
                    aout       = addr;
                end
                OPC_RD: begin
                    cmd[C_RD] = 1'b1;
                    bank      = ba;
                    aout      = col_ext;
                    qual      = addr[AP_BIT];
                end
                OPC_WR: begin
                    cmd[C_WR] = 1'b1;
                    bank      = ba;
                    aout      = col_ext;
                    qual      = addr[AP_BIT];
                end
                OPC_BST: cmd[C_BST] = 1'b1;
                OPC_PRE: begin
                    cmd[C_PRE] = 1'b1;
                    qual       = addr[AP_BIT];
                    bank       = addr[AP_BIT] ? '0 : ba;
                end
                OPC_REF: cmd[C_AREF] = 1'b1;
                default: cmd[C_LMR]  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mode_check.sv
module sdram_mode_check
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              wr_en,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  mode_t             cur,
    output mode_t             nxt,
    output logic              err
);

    localparam int OP_LO = 7;
    localparam int OP_W  = ADDR_W - OP_LO;
    localparam logic [OP_W-1:0] OP_NORMAL = '0;
    localparam logic [OP_W-1:0] OP_DLLRST = OP_W'(2);

    logic [OP_W-1:0] op_f;
    logic            bl_ok;
    logic            cl_ok;
    logic            op_ok;
    logic            dll_req;
    logic            ext_ok;

    assign op_f    = addr[ADDR_W-1:OP_LO];
    assign bl_ok   = (addr[2:0] == 3'b001) || (addr[2:0] == 3'b010) || (addr[2:0] == 3'b011);
    assign cl_ok   = (addr[6:4] == 3'b010) || (addr[6:4] == 3'b011);
    assign dll_req = (op_f == OP_DLLRST);
    assign op_ok   = (op_f == OP_NORMAL) || dll_req;
    assign ext_ok  = (addr[ADDR_W-1:1] == '0);

    always_comb begin
        nxt         = cur;
        nxt.dll_rst = 1'b0;      // self-clearing
        err         = 1'b0;
        if (wr_en) begin
            if (ba == BA_W'(0)) begin
                if (bl_ok && cl_ok && op_ok) begin
                    nxt.bl      = addr[2:0];
                    nxt.bt      = addr[3];
                    nxt.cl      = addr[6:4];
                    nxt.dll_rst = dll_req;
                end else begin
                    err = 1'b1;
                end
            end else if (ba == BA_W'(1)) begin
                if (ext_ok) begin
                    nxt.dll_en = ~addr[0];
                end else begin
                    err = 1'b1;
                end
            end else begin
                err = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs
    import sdram_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t nxt,
    input  logic  err_in,
    output mode_t mode_q,
    output logic  err_q
);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d.mode = nxt;
        st_d.err  = err_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RST, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign err_q  = st_q.err;

    // R8: a rejected write keeps every stored field
    p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($stable(mode_q.bl) && $stable(mode_q.bt) &&
                   $stable(mode_q.cl) && $stable(mode_q.dll_en) && !mode_q.dll_rst));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CMD_N-1:0]  cmd_oh_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              qual_o,
    output logic [2:0]        bl_o,
    output logic              bt_o,
    output logic [2:0]        cl_o,
    output logic              dll_rst_o,
    output logic              dll_en_o,
    output logic              mr_err_o
);

    typedef struct packed {
        logic [CMD_N-1:0]  cmd;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
        logic              qual;
    } out_t;

    logic [CMD_N-1:0]  dec_cmd;
    logic [BA_W-1:0]   dec_bank;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_qual;
    mode_t             chk_nxt;
    logic              chk_err;
    mode_t             mode_q;
    logic              err_q;
    out_t              out_d;
    out_t              out_q;

    sdram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .COL_W  (COL_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cke   (cke_i),
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .ba    (ba_i),
        .addr  (addr_i),
        .cmd   (dec_cmd),
        .bank  (dec_bank),
        .aout  (dec_addr),
        .qual  (dec_qual)
    );

    sdram_mode_check #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_check (
        .wr_en (dec_cmd[C_LMR]),
        .ba    (ba_i),
        .addr  (addr_i),
        .cur   (mode_q),
        .nxt   (chk_nxt),
        .err   (chk_err)
    );

    sdram_mode_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (chk_nxt),
        .err_in (chk_err),
        .mode_q (mode_q),
        .err_q  (err_q)
    );

    always_comb begin
        out_d.cmd  = dec_cmd;
        out_d.bank = dec_bank;
        out_d.addr = dec_addr;
        out_d.qual = dec_qual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_oh_o  = out_q.cmd;
    assign bank_o    = out_q.bank;
    assign addr_o    = out_q.addr;
    assign qual_o    = out_q.qual;
    assign bl_o      = mode_q.bl;
    assign bt_o      = mode_q.bt;
    assign cl_o      = mode_q.cl;
    assign dll_rst_o = mode_q.dll_rst;
    assign dll_en_o  = mode_q.dll_en;
    assign mr_err_o  = err_q;

    // R2: never more than one strobe
    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_oh_o));

    // R1: deselect with the clock enabled always reports NOP
    p_deselect_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_i && cs_n_i) |=> (cmd_oh_o == {{(CMD_N-1){1'b0}}, 1'b1}));

    // R3: self refresh only from a low clock enable, auto refresh only from high
    p_sref_needs_low_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh_o[C_SREF] |-> !$past(cke_i));
    p_aref_needs_high_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh_o[C_AREF] |-> $past(cke_i));

    // R4: qualifier only accompanies read, write or precharge
    p_qual_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> (cmd_oh_o[C_RD] || cmd_oh_o[C_WR] || cmd_oh_o[C_PRE]));

    // R5: column reports carry no bits above the column field
    p_col_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oh_o[C_RD] || cmd_oh_o[C_WR]) |-> (addr_o >> COL_W) == '0);

    // R7: DLL reset pulse only with a load-mode strobe
    p_dllrst_with_lmr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst_o |-> cmd_oh_o[C_LMR]);

    // R8: the error pulse only with a load-mode strobe
    p_err_with_lmr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mr_err_o |-> cmd_oh_o[C_LMR]);

endmodule

// File: tb/sdram_cmd_front_bench.sv
module sdram_cmd_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [8:0]  cmd_oh;
    logic [1:0]  bank;
    logic [11:0] aout;
    logic        qual, bt, dll_rst, dll_en, mr_err;
    logic [2:0]  bl, cl;

    always #4 clk = ~clk;

    sdram_cmd_front u_sdram_cmd_front (
        .clk (clk), .rst_n (rst_n), .cke_i (cke), .cs_n_i (cs_n),
        .ras_n_i (ras_n), .cas_n_i (cas_n), .we_n_i (we_n), .ba_i (ba),
        .addr_i (addr), .cmd_oh_o (cmd_oh), .bank_o (bank), .addr_o (aout),
        .qual_o (qual), .bl_o (bl), .bt_o (bt), .cl_o (cl),
        .dll_rst_o (dll_rst), .dll_en_o (dll_en), .mr_err_o (mr_err)
    );

    typedef struct {
        logic [8:0]  cmd;
        logic [1:0]  bank;
        logic [11:0] addr;
        logic        qual;
        logic [2:0]  bl;
        logic        bt;
        logic [2:0]  cl;
        logic        dll_rst;
        logic        dll_en;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Reference model state, from the requirements
    logic [2:0] m_bl = 3'b010;
    logic       m_bt = 1'b0;
    logic [2:0] m_cl = 3'b011;
    logic       m_en = 1'b1;

    task automatic compare(input exp_t e);
        n_chk++;
        if (cmd_oh !== e.cmd || bank !== e.bank || aout !== e.addr || qual !== e.qual ||
            bl !== e.bl || bt !== e.bt || cl !== e.cl || dll_rst !== e.dll_rst ||
            dll_en !== e.dll_en || mr_err !== e.err) begin
            n_fail++;
            $display("FAIL %s: got cmd=%b bank=%0d addr=%h qual=%b bl=%b bt=%b cl=%b dllrst=%b dllen=%b err=%b; expected cmd=%b bank=%0d addr=%h qual=%b bl=%b bt=%b cl=%b dllrst=%b dllen=%b err=%b",
                e.tag, cmd_oh, bank, aout, qual, bl, bt, cl, dll_rst, dll_en, mr_err,
                e.cmd, e.bank, e.addr, e.qual, e.bl, e.bt, e.cl, e.dll_rst, e.dll_en, e.err);
        end
    endtask

    // Driver: applies one command per cycle and pushes its expected result
    task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                         input logic w, input logic [1:0] b, input logic [11:0] a,
                         input string tag);
        exp_t e;
        logic [2:0] opc;
        logic ok;
        @(posedge clk);
        #1;
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
        e.cmd = '0; e.bank = '0; e.addr = '0; e.qual = 1'b0;
        e.dll_rst = 1'b0; e.err = 1'b0; e.tag = tag;
        opc = {r, ca, w};
        if (!k) begin
            if (!c && opc == 3'b001) e.cmd[7] = 1'b1;
        end else if (c) begin
            e.cmd[0] = 1'b1;
        end else begin
            case (opc)
                3'b111: e.cmd[0] = 1'b1;
                3'b011: begin e.cmd[1] = 1'b1; e.bank = b; e.addr = a; end
                3'b101: begin e.cmd[2] = 1'b1; e.bank = b; e.addr = {2'b00, a[9:0]}; e.qual = a[10]; end
                3'b100: begin e.cmd[3] = 1'b1; e.bank = b; e.addr = {2'b00, a[9:0]}; e.qual = a[10]; end
                3'b110: e.cmd[4] = 1'b1;
                3'b010: begin e.cmd[5] = 1'b1; e.qual = a[10]; e.bank = a[10] ? 2'd0 : b; end
                3'b001: e.cmd[6] = 1'b1;
                default: begin
                    e.cmd[8] = 1'b1;
                    if (b == 2'd0) begin
                        ok = (a[2:0] >= 3'd1 && a[2:0] <= 3'd3) &&
                             (a[6:4] == 3'd2 || a[6:4] == 3'd3) &&
                             (a[11:7] == 5'b00000 || a[11:7] == 5'b00010);
                        if (ok) begin
                            m_bl = a[2:0]; m_bt = a[3]; m_cl = a[6:4];
                            e.dll_rst = a[8];
                        end else e.err = 1'b1;
                    end else if (b == 2'd1) begin
                        if (a[11:1] == '0) m_en = ~a[0];
                        else e.err = 1'b1;
                    end else e.err = 1'b1;
                end
            endcase
        end
        e.bl = m_bl; e.bt = m_bt; e.cl = m_cl; e.dll_en = m_en;
        q.push_back(e);
    endtask

    // Monitor: pops the item whose command was captured at the last edge
    initial begin
        int n;
        wait (rst_n);
        forever begin
            @(posedge clk);
            n = q.size();
            @(negedge clk);
            if (n > 0) compare(q.pop_front());
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r = '{cmd: '0, bank: '0, addr: '0, qual: 1'b0, bl: 3'b010, bt: 1'b0, cl: 3'b011,
              dll_rst: 1'b0, dll_en: 1'b1, err: 1'b0, tag: "R10 reset state"};
        compare(r);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        r.tag = "R10 idle after reset release";
        compare(r);

        // R1: deselect masks any opcode
        drive(1, 1, 0, 0, 0, 2'd0, 12'h000, "R1 deselect masks load-mode");
        drive(1, 1, 0, 1, 1, 2'd3, 12'hFFF, "R1 deselect masks active");
        // R2: every encoding
        drive(1, 0, 1, 1, 1, 2'd0, 12'h000, "R2 nop");
        drive(1, 0, 1, 1, 0, 2'd1, 12'h400, "R2 burst stop");
        // R5: active with bank and row
        drive(1, 0, 0, 1, 1, 2'd2, 12'hABC, "R5 active bank/row");
        // R4/R5: read and write with and without auto precharge
        drive(1, 0, 1, 0, 1, 2'd1, 12'hD55, "R4 read auto-precharge, R5 column");
        drive(1, 0, 1, 0, 0, 2'd3, 12'h3FF, "R4 write no auto-precharge");
        drive(1, 0, 1, 0, 0, 2'd0, 12'h401, "R4 write auto-precharge");
        // R5: precharge all ignores BA, single keeps it
        drive(1, 0, 0, 1, 0, 2'd3, 12'h400, "R5 precharge all banks");
        drive(1, 0, 0, 1, 0, 2'd1, 12'h000, "R5 precharge single bank");
        // R3: refresh variants and clock-disabled sampling
        drive(1, 0, 0, 0, 1, 2'd0, 12'h000, "R3 auto refresh");
        drive(0, 0, 0, 0, 1, 2'd2, 12'h123, "R3 self refresh entry");
        drive(0, 0, 1, 0, 1, 2'd1, 12'h400, "R3 read ignored with cke low");
        drive(0, 1, 0, 0, 1, 2'd0, 12'h000, "R3 deselect with cke low");
        drive(0, 0, 0, 0, 0, 2'd0, 12'h02B, "R3 load-mode ignored with cke low");
        // R6: base mode write
        drive(1, 0, 0, 0, 0, 2'd0, 12'h02B, "R6 base BL8 interleaved CL2");
        drive(1, 0, 1, 1, 1, 2'd0, 12'h000, "R6 fields held after write");
        // R8: rejected operands
        drive(1, 0, 0, 0, 0, 2'd0, 12'h030, "R8 reserved burst code");
        drive(1, 0, 0, 0, 0, 2'd0, 12'h042, "R8 reserved CAS code");
        drive(1, 0, 0, 0, 0, 2'd0, 12'h232, "R8 reserved operating mode A9");
        drive(1, 0, 0, 0, 0, 2'd0, 12'h1B2, "R8 reserved operating mode A8+A7");
        drive(1, 0, 0, 0, 0, 2'd2, 12'h000, "R8 reserved register select");
        drive(1, 0, 0, 0, 0, 2'd1, 12'h002, "R8 reserved extended bit");
        // R7: DLL reset with legal fields, then self-clear
        drive(1, 0, 0, 0, 0, 2'd0, 12'h132, "R7 DLL reset pulse");
        drive(1, 0, 1, 1, 1, 2'd0, 12'h000, "R7 DLL reset cleared");
        drive(1, 0, 0, 0, 0, 2'd0, 12'h011, "R6 base BL2 CL... reserved CAS 001");
        drive(1, 0, 0, 0, 0, 2'd0, 12'h039, "R6 base BL2 interleaved CL3");
        // R9: extended register
        drive(1, 0, 0, 0, 0, 2'd1, 12'h001, "R9 DLL disable");
        drive(1, 1, 1, 1, 1, 2'd0, 12'h000, "R9 disable held");
        drive(1, 0, 0, 0, 0, 2'd1, 12'h000, "R9 DLL enable");
        drive(1, 0, 1, 1, 1, 2'd0, 12'h000, "R2 trailing nop");

        @(posedge clk); #1;
        cke = 1; cs_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule